// File: doc/BRIEF.md
# Wide Field Adder with Carry Bubbling

The block adds two wide operands that are cut into `NUM_FIELDS` fields of `FIELD_W` bits each. It does not run a carry chain through the whole word. All field sums are formed side by side, with no carry moving between fields. Three small masks are then taken from the fields:

- the top bit of each operand field;
- the top bit of each partial sum;
- a flag for each partial sum that is all ones.

A narrow mask network uses these masks to decide which fields take an incoming carry. That decision covers carries that pass through a run of all-ones fields. It uses one add-and-mask step of `NUM_FIELDS + 1` bits.

Once the carries are known, every chosen field is incremented in parallel. The final sum and the carry-out are registered. A carry-in enters below the lowest field. The carry-out leaves above the highest field, so that several adders can be chained to build a wider sum.

Top module: `wfa_top`

## Requirements
- R1: While `rst_ni` is low, `sum_o` and `cout_o` are zero, and they stay zero until the first rising clock edge after reset is released.
- R2: Operands sampled at a rising edge appear on `{cout_o, sum_o}` right after that edge. The outputs do not change between edges.
- R3: `{cout_o, sum_o}` equals the full-width sum `a_i + b_i + cin_i`, taken one bit wider than the operands.
- R4: A field whose partial sum overflows adds one to the next field up. A field overflows when both top bits are set, or when one top bit is set and the top bit of the partial sum is clear.
- R5: A carry that enters a field whose partial sum is all ones passes on to the next field up. That field becomes zero, and this holds through a run of any length.
- R6: `cin_i` = 1 adds one to field 0 and may bubble from there. `cin_i` = 0 leaves every field equal to its partial sum unless a lower field carries into it.
- R7: `cout_o` is the carry that leaves the highest field, whether that field generates it or passes it on. All-ones plus zero with `cin_i` = 1 gives a zero sum and `cout_o` = 1.
- R8: With 8 fields of 8 bits, the operands 0x1931BA4C3D4521F1 and 0x221245B3E2161736 with no carry-in give 0x3B4400001F5B3927. Exactly four fields differ from their partial sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | NUM_FIELDS*FIELD_W | First operand, field 0 in the low bits |
| b_i | input | NUM_FIELDS*FIELD_W | Second operand |
| cin_i | input | 1 | Carry into field 0 |
| sum_o | output | NUM_FIELDS*FIELD_W | Registered sum |
| cout_o | output | 1 | Registered carry out of the top field |

## Verification
The hardest case to reach from the ports is a carry that passes through several all-ones partial sums, ending either in a field that absorbs it or above the top field. Random operands almost never give a partial sum of all ones. The bench therefore builds operands field by field: one low field generates a carry, or the carry-in supplies it, and the fields above it sum to exactly all ones. The runs it builds end at different fields, including one that leaves through the carry-out. A second instance with narrow fields runs the worked 8-bit example. Results are also chained across two adds to form a double-width sum.

// File: rtl/wfa_pkg.sv
package wfa_pkg;
  localparam int unsigned DEF_NUM_FIELDS = 8;
  localparam int unsigned DEF_FIELD_W    = 64;

  // lane masks handled by the carry network are kept narrow
  localparam int unsigned MAX_NUM_FIELDS = 64;
endpackage

// File: rtl/wfa_field_sum.sv
module wfa_field_sum #(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned FIELD_W    = 64,
  localparam int unsigned TOT_W     = NUM_FIELDS * FIELD_W
) (
  input  logic [TOT_W-1:0]      a_i,
  input  logic [TOT_W-1:0]      b_i,
  output logic [TOT_W-1:0]      part_o,
  output logic [NUM_FIELDS-1:0] a_hi_o,
  output logic [NUM_FIELDS-1:0] b_hi_o,
  output logic [NUM_FIELDS-1:0] p_hi_o,
  output logic [NUM_FIELDS-1:0] ones_o
);
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_fld
    logic [FIELD_W-1:0] fa, fb, fs;
    assign fa = a_i[k*FIELD_W +: FIELD_W];
    assign fb = b_i[k*FIELD_W +: FIELD_W];
    assign fs = fa + fb;  // carry between fields dropped on purpose
    assign part_o[k*FIELD_W +: FIELD_W] = fs;
    assign a_hi_o[k] = fa[FIELD_W-1];
    assign b_hi_o[k] = fb[FIELD_W-1];
    assign p_hi_o[k] = fs[FIELD_W-1];
    assign ones_o[k] = &fs;
  end
endmodule

// File: rtl/wfa_carry_net.sv
module wfa_carry_net #(
  parameter int unsigned NUM_FIELDS = 8,
  localparam int unsigned MW        = NUM_FIELDS + 1
) (
  input  logic [NUM_FIELDS-1:0] a_hi_i,
  input  logic [NUM_FIELDS-1:0] b_hi_i,
  input  logic [NUM_FIELDS-1:0] p_hi_i,
  input  logic [NUM_FIELDS-1:0] ones_i,
  input  logic                  cin_i,
  output logic [NUM_FIELDS-1:0] gen_o,
  output logic [NUM_FIELDS-1:0] inc_o,
  output logic                  cout_o
);
  logic [MW-1:0] marker, pass, seed, spread, reach;

  assign gen_o  = (a_hi_i & b_hi_i) | ((a_hi_i | b_hi_i) & ~p_hi_i);
  // carries land one field up; carry-in lands on field 0
  assign marker = {gen_o, cin_i};
  assign pass   = {1'b0, ones_i};
  // reach every field a marker can move to through all-ones fields
  assign seed   = marker & pass;
  assign spread = seed + pass;
  assign reach  = (spread ^ pass) | marker;

  assign inc_o  = reach[NUM_FIELDS-1:0];
  assign cout_o = reach[NUM_FIELDS];
endmodule

// File: rtl/wfa_field_inc.sv
module wfa_field_inc #(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned FIELD_W    = 64,
  localparam int unsigned TOT_W     = NUM_FIELDS * FIELD_W
) (
  input  logic [TOT_W-1:0]      part_i,
  input  logic [NUM_FIELDS-1:0] inc_i,
  output logic [TOT_W-1:0]      sum_o
);
  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_inc
    assign sum_o[k*FIELD_W +: FIELD_W] =
      part_i[k*FIELD_W +: FIELD_W] + {{(FIELD_W-1){1'b0}}, inc_i[k]};
  end
endmodule

// File: rtl/wfa_top.sv
module wfa_top #(
  parameter int unsigned NUM_FIELDS = wfa_pkg::DEF_NUM_FIELDS,
  parameter int unsigned FIELD_W    = wfa_pkg::DEF_FIELD_W,
  localparam int unsigned TOT_W     = NUM_FIELDS * FIELD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOT_W-1:0] a_i,
  input  logic [TOT_W-1:0] b_i,
  input  logic             cin_i,
  output logic [TOT_W-1:0] sum_o,
  output logic             cout_o
);
  logic [TOT_W-1:0]      part_sum, next_sum;
  logic [NUM_FIELDS-1:0] a_hi, b_hi, p_hi;
  logic [NUM_FIELDS-1:0] gen_mask, bub_mask, inc_mask;
  logic                  carry_out;

  wfa_field_sum #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_sum (
    .a_i(a_i), .b_i(b_i), .part_o(part_sum),
    .a_hi_o(a_hi), .b_hi_o(b_hi), .p_hi_o(p_hi), .ones_o(bub_mask)
  );

  wfa_carry_net #(.NUM_FIELDS(NUM_FIELDS)) u_net (
    .a_hi_i(a_hi), .b_hi_i(b_hi), .p_hi_i(p_hi), .ones_i(bub_mask),
    .cin_i(cin_i), .gen_o(gen_mask), .inc_o(inc_mask), .cout_o(carry_out)
  );

  wfa_field_inc #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_inc (
    .part_i(part_sum), .inc_i(inc_mask), .sum_o(next_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= next_sum;
      cout_o <= carry_out;
    end
  end
endmodule

// File: rtl/wfa_checker.sv
module wfa_checker #(
  parameter int unsigned NUM_FIELDS = 8,
  parameter int unsigned FIELD_W    = 64,
  localparam int unsigned TOT_W     = NUM_FIELDS * FIELD_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [TOT_W-1:0]      a_i,
  input logic [TOT_W-1:0]      b_i,
  input logic                  cin_i,
  input logic [TOT_W-1:0]      sum_o,
  input logic                  cout_o,
  input logic [NUM_FIELDS-1:0] gen_mask,
  input logic [NUM_FIELDS-1:0] bub_mask,
  input logic [NUM_FIELDS-1:0] inc_mask,
  input logic                  carry_out
);
  logic [TOT_W:0] full_sum;
  assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{TOT_W{1'b0}}, cin_i};

  assert_reset_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (sum_o == '0 && !cout_o));

  assert_full_sum_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ({cout_o, sum_o} == $past(full_sum)));

  assert_cin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_mask[0] == cin_i);

  assert_cout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_out == (gen_mask[NUM_FIELDS-1] ||
                  (inc_mask[NUM_FIELDS-1] && bub_mask[NUM_FIELDS-1])));

  assert_cout_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cout_o == $past(carry_out)));

  for (genvar k = 1; k < NUM_FIELDS; k++) begin : g_chk
    assert_gen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gen_mask[k-1] |-> inc_mask[k]);
    assert_bubble_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_mask[k-1] && bub_mask[k-1]) |-> inc_mask[k]);
    assert_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inc_mask[k] |-> (gen_mask[k-1] || (inc_mask[k-1] && bub_mask[k-1])));
  end
endmodule

bind wfa_top wfa_checker #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/wfa_top_tb.sv
module wfa_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int FW = 64;
  localparam int TW = NF * FW;
  localparam int SW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] a, b, sum;
  logic cin, cout;
  logic [SW-1:0] a8, b8, sum8;
  logic cin8, cout8;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wfa_top #(.NUM_FIELDS(NF), .FIELD_W(FW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout));

  wfa_top #(.NUM_FIELDS(8), .FIELD_W(8)) u_dut_small (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a8), .b_i(b8), .cin_i(cin8),
    .sum_o(sum8), .cout_o(cout8));

  task automatic chk(input string req, input logic [TW:0] act, input logic [TW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] rand_wide();
    logic [TW-1:0] v = '0;
    for (int j = 0; j < TW/32; j++) v[j*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [TW:0] model(logic [TW-1:0] x, logic [TW-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{TW{1'b0}}, c};
  endfunction

  task automatic apply(input logic [TW-1:0] x, input logic [TW-1:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 sum in reset", {cout, sum}, '0);
    @(negedge clk);
    a = '1; b = '1; cin = 1'b1;
    #1 chk("R1 held in reset", {cout, sum}, '0);
    rst_n = 1'b1;
    #1 chk("R1 zero before first edge", {cout, sum}, '0);
    @(negedge clk);
    chk("R3 first add after reset", {cout, sum}, model('1, '1, 1'b1));
  endtask

  task automatic t_latency();
    logic [TW:0] prev;
    apply(TW'(5), TW'(7), 1'b0);
    prev = {cout, sum};
    a = TW'(100); b = TW'(1);
    #1 chk("R2 output stable before edge", {cout, sum}, prev);
    @(negedge clk);
    chk("R2 result after one edge", {cout, sum}, model(TW'(100), TW'(1), 1'b0));
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [TW-1:0] x, y;
      logic c;
      x = rand_wide(); y = rand_wide(); c = n[0];
      apply(x, y, c);
      chk("R3 random", {cout, sum}, model(x, y, c));
    end
  endtask

  task automatic t_generate();
    logic [TW-1:0] x = '0, y = '0;
    x[FW-1] = 1'b1; y[FW-1] = 1'b1;  // field 0 overflows
    x[2*FW-1] = 1'b1; y[FW +: 8] = 8'h80;  // field 1 top bit set, no overflow alone
    apply(x, y, 1'b0);
    chk("R4 generate into next field", {cout, sum}, model(x, y, 1'b0));
  endtask

  task automatic t_bubble();
    for (int top = 1; top < NF; top++) begin
      logic [TW-1:0] x = '0, y = '0;
      x[FW-1:0] = '1; y[0] = 1'b1;  // field 0 generates
      for (int k = 1; k < top; k++) x[k*FW +: FW] = '1;
      x[top*FW +: FW] = FW'(3);
      apply(x, y, 1'b0);
      chk("R5 bubble run", {cout, sum}, model(x, y, 1'b0));
    end
  endtask

  task automatic t_cin();
    logic [TW-1:0] x;
    x = {{(TW-FW){1'b0}}, {FW{1'b1}}};
    apply(x, '0, 1'b1);
    chk("R6 carry-in bubbles from field 0", {cout, sum}, model(x, '0, 1'b1));
    apply(x, '0, 1'b0);
    chk("R6 no carry-in leaves fields", {cout, sum}, {1'b0, x});
    apply('1, '0, 1'b0);
    chk("R6 all ones without carry-in", {cout, sum}, {1'b0, {TW{1'b1}}});
  endtask

  task automatic t_cout();
    logic [TW-1:0] x = '0, y = '0;
    apply('1, '0, 1'b1);
    chk("R7 ripple through every field", {cout, sum}, {1'b1, {TW{1'b0}}});
    x[(NF-1)*FW +: FW] = '1; y[(NF-1)*FW] = 1'b1;
    apply(x, y, 1'b0);
    chk("R7 top field generates", {cout, sum}, {1'b1, {TW{1'b0}}});
    apply('1, '1, 1'b1);
    chk("R7 max operands", {cout, sum}, {1'b1, {TW{1'b1}}});
  endtask

  task automatic t_chain();
    logic [TW-1:0] lo_a, lo_b, hi_a, hi_b, lo_s;
    logic [2*TW:0] exp;
    logic c;
    lo_a = '1; lo_b = TW'(1); hi_a = rand_wide(); hi_b = '1;
    apply(lo_a, lo_b, 1'b0);
    lo_s = sum; c = cout;
    apply(hi_a, hi_b, c);
    exp = {1'b0, hi_a, lo_a} + {1'b0, hi_b, lo_b};
    chk("R3 chained low half", {1'b0, lo_s}, {1'b0, exp[TW-1:0]});
    chk("R7 chained high half", {cout, sum}, exp[2*TW:TW]);
  endtask

  task automatic t_example();
    logic [SW-1:0] part;
    int diff = 0;
    @(negedge clk);
    a8 = 64'h1931BA4C3D4521F1; b8 = 64'h221245B3E2161736; cin8 = 1'b0;
    @(negedge clk);
    chk("R8 example sum", {{(TW-SW){1'b0}}, cout8, sum8}, {{(TW-SW){1'b0}}, 1'b0, 64'h3B4400001F5B3927});
    for (int k = 0; k < 8; k++) begin
      part[k*8 +: 8] = a8[k*8 +: 8] + b8[k*8 +: 8];
      if (part[k*8 +: 8] != sum8[k*8 +: 8]) diff++;
    end
    chk("R8 four fields incremented", (TW+1)'(diff), (TW+1)'(4));
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; a8 = '0; b8 = '0; cin8 = 1'b0;
    #(CLK_PERIOD*2);
    t_reset();
    t_latency();
    t_random();
    t_generate();
    t_bubble();
    t_cin();
    t_cout();
    t_chain();
    t_example();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule